// File: doc/BRIEF.md
# Dual-Buffer Serial Shift Transmitter

This block turns 16-bit words into a serial bit stream on one output pin and drives a matching shift clock on a second pin. Two shadow word registers work as a ping-pong pair. Software writes either register through a shared data bus, using a separate strobe for each register. The serialiser drains one register and then moves straight to the other. While one word is going out, the next can be written. The payload must be led by a word whose top bit is 1 (for example 0x8000), so that a receiver can lock onto the first 1 as a start marker.

The bit rate comes from the core clock through two cascaded divider settings. Their product sets how many core cycles one bit lasts. Transfers run in one of two clocking sub-modes. In free-running mode the shift clock keeps toggling until software stops it. In fixed-count mode the shift clock stops by itself after a programmed number of bits (1 to 255), and a sticky completion flag is raised.

Top module: `pingpong_shift_tx`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sh_clk`, `sh_dout`, `done`, `busy` and both `buf_full` bits are 0.
- R2: Each divider setting counts as 1 when it is 0 or 1. One bit lasts P = max(2, a*b) core cycles, where a and b are the two settings as counted. `sh_clk` is high for floor(P/2) of those cycles. Both settings are captured when a transfer starts.
- R3: `sh_dout` takes a new value only in the cycle where `sh_clk` rises, or when a transfer ends. The first rise comes on the clock edge that samples `start`.
- R4: Words leave most significant bit first. After reset, shadow buffer 0 is sent first. After each buffer that is taken, the serialiser moves to the other buffer, with no idle bit between words.
- R5: If the buffer due at a word boundary is empty, 16 zero bits are sent and that same buffer stays due for the next boundary.
- R6: `ld_buf0` and `ld_buf1` each write `ld_data` into their own buffer and set that buffer's `buf_full` bit (bit 0 for buffer 0, bit 1 for buffer 1) on the next cycle. A buffer's full bit clears when the serialiser takes its word. A word loaded while the other buffer is shifting is used at the next boundary.
- R7: With `cfg_fixed`=1, a transfer gives exactly `cfg_count` rises of `sh_clk`. Then `sh_clk` and `busy` go low, and `done` is set count*P cycles after the start edge. A count of 0 sets `done` on the next cycle with no clock pulse.
- R8: `done` stays set until `done_clr` is pulsed or a fixed-count transfer starts. A free-running start leaves `done` unchanged.
- R9: With `cfg_fixed`=0, the shift clock runs until a `stop` pulse. After that pulse, `busy`, `sh_clk` and `sh_dout` are 0 on the next cycle. A `start` pulse while busy has no effect.
- R10: `sh_clk` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_data | input | 16 | Word to write into a shadow buffer |
| ld_buf0 | input | 1 | Write strobe for shadow buffer 0 |
| ld_buf1 | input | 1 | Write strobe for shadow buffer 1 |
| cfg_div_a | input | 8 | First divider stage setting |
| cfg_div_b | input | 8 | Second divider stage setting |
| cfg_fixed | input | 1 | 1 = fixed-count sub-mode, 0 = free-running |
| cfg_count | input | 8 | Bits per fixed-count transfer |
| start | input | 1 | Start pulse |
| stop | input | 1 | Stop pulse (ends a transfer at once) |
| done_clr | input | 1 | Clears the completion flag |
| sh_clk | output | 1 | Generated shift clock |
| sh_dout | output | 1 | Serial data |
| done | output | 1 | Sticky fixed-count completion flag |
| busy | output | 1 | Transfer in progress |
| buf_full | output | 2 | Per-buffer holds-unsent-word flags |

## Verification
A table of fixed-count runs covers several divider pairs. These include settings of 0 and 1 that are counted as 1, an even product, an odd product of 5 that exposes the split of high and low time, and an even product of 6. The table also pairs word lengths of 1, 16, 20, 24, 32 and 40 bits with payloads such as all-ones and alternating patterns. Together these runs separate a wrong bit order, a wrong buffer order, a wrong cycle count per bit, a wrong stop point and missing zero fill. A long free-running run refills buffer 0 during shifting and leaves buffer 1 empty for one boundary before refilling it, which shows whether the ping-pong pointer advances only on real words. Short directed runs check the sticky flag against clear, free start and fixed start, and also the zero-length request.

// File: rtl/pp_shift_pkg.sv
package pp_shift_pkg;
  typedef enum logic {
    CLK_FREE  = 1'b0,
    CLK_FIXED = 1'b1
  } clk_mode_e;
endpackage

// File: rtl/pp_period_gen.sv
// Bit-period timer: the two divider settings are multiplied into one period.
module pp_period_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             run,
  input  logic [DIV_W-1:0] div_a,
  input  logic [DIV_W-1:0] div_b,
  output logic             wrap,
  output logic             mid
);
  localparam int PW = 2 * DIV_W;

  logic [DIV_W-1:0] eff_a, eff_b;
  logic [PW-1:0]    prod, per_next;
  logic [PW-1:0]    per_q, half_q, phase_q;

  always_comb begin
    eff_a    = (div_a < DIV_W'(2)) ? DIV_W'(1) : div_a;
    eff_b    = (div_b < DIV_W'(2)) ? DIV_W'(1) : div_b;
    prod     = PW'(eff_a) * PW'(eff_b);
    per_next = (prod < PW'(2)) ? PW'(2) : prod;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q   <= PW'(2);
      half_q  <= PW'(1);
      phase_q <= '0;
    end else if (launch) begin
      per_q   <= per_next;
      half_q  <= per_next >> 1;
      phase_q <= '0;
    end else if (run) begin
      phase_q <= wrap ? '0 : phase_q + PW'(1);
    end
  end

  assign wrap = run && (phase_q == per_q - PW'(1));
  assign mid  = run && (phase_q == half_q - PW'(1));
endmodule

// File: rtl/pp_shadow_pair.sv
// Two shadow words with independent write strobes and a ping-pong read pointer.
module pp_shadow_pair #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [1:0]        ld,
  input  logic              take,
  output logic [WORD_W-1:0] cur_word,
  output logic              cur_valid,
  output logic [1:0]        full
);
  logic [1:0][WORD_W-1:0] words;
  logic                   sel_q;

  for (genvar g = 0; g < 2; g++) begin : g_buf
    logic [WORD_W-1:0] word_q;
    logic              full_q;

    always_ff @(posedge clk) begin
      if (ld[g]) word_q <= ld_data;
    end

    always_ff @(posedge clk) begin
      if (rst)                                  full_q <= 1'b0;
      else if (ld[g])                           full_q <= 1'b1;
      else if (take && (sel_q == 1'(g)) && full_q) full_q <= 1'b0;
    end

    assign words[g] = word_q;
    assign full[g]  = full_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                     sel_q <= 1'b0;
    else if (take && full[sel_q]) sel_q <= ~sel_q;
  end

  assign cur_word  = words[sel_q];
  assign cur_valid = full[sel_q];
endmodule

// File: rtl/pp_serializer.sv
// Transfer sequencer and shift register; drives the registered pin outputs.
module pp_serializer
  import pp_shift_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              done_clr,
  input  clk_mode_e         mode,
  input  logic [CNT_W-1:0]  count,
  input  logic              wrap,
  input  logic              mid,
  input  logic [WORD_W-1:0] word,
  input  logic              word_valid,
  output logic              take,
  output logic              launch,
  output logic              active,
  output logic              sh_clk,
  output logic              sh_dout,
  output logic              done
);
  localparam int BP_W = $clog2(WORD_W + 1);

  logic              active_q, fixed_q, clk_q, dout_q, done_q;
  logic [WORD_W-1:0] sreg_q, new_word;
  logic [BP_W-1:0]   bitpos_q;
  logic [CNT_W-1:0]  left_q;
  logic              last_bit, boundary, zero_req;

  always_comb begin
    new_word = word_valid ? word : '0;
    zero_req = (mode == CLK_FIXED) && (count == '0);
    last_bit = fixed_q && (left_q == '0);
    boundary = (bitpos_q == BP_W'(WORD_W));
    launch   = start && !active_q && !zero_req;
    take     = launch || (active_q && !stop && wrap && !last_bit && boundary);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      fixed_q  <= 1'b0;
      clk_q    <= 1'b0;
      dout_q   <= 1'b0;
      done_q   <= 1'b0;
      sreg_q   <= '0;
      bitpos_q <= '0;
      left_q   <= '0;
    end else begin
      if (done_clr) done_q <= 1'b0;
      if (!active_q) begin
        if (start) begin
          if (mode == CLK_FIXED) done_q <= 1'b0;
          if (zero_req) begin
            done_q <= 1'b1;
          end else begin
            active_q <= 1'b1;
            fixed_q  <= (mode == CLK_FIXED);
            left_q   <= count - CNT_W'(1);
            clk_q    <= 1'b1;
            dout_q   <= new_word[WORD_W-1];
            sreg_q   <= new_word << 1;
            bitpos_q <= BP_W'(1);
          end
        end
      end else if (stop) begin
        active_q <= 1'b0;
        clk_q    <= 1'b0;
        dout_q   <= 1'b0;
      end else begin
        if (mid) clk_q <= 1'b0;
        if (wrap) begin
          if (last_bit) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
            clk_q    <= 1'b0;
            dout_q   <= 1'b0;
          end else begin
            clk_q <= 1'b1;
            if (fixed_q) left_q <= left_q - CNT_W'(1);
            if (boundary) begin
              dout_q   <= new_word[WORD_W-1];
              sreg_q   <= new_word << 1;
              bitpos_q <= BP_W'(1);
            end else begin
              dout_q   <= sreg_q[WORD_W-1];
              sreg_q   <= sreg_q << 1;
              bitpos_q <= bitpos_q + BP_W'(1);
            end
          end
        end
      end
    end
  end

  assign active  = active_q;
  assign sh_clk  = clk_q;
  assign sh_dout = dout_q;
  assign done    = done_q;
endmodule

// File: rtl/pingpong_shift_tx.sv
module pingpong_shift_tx
  import pp_shift_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              ld_buf0,
  input  logic              ld_buf1,
  input  logic [DIV_W-1:0]  cfg_div_a,
  input  logic [DIV_W-1:0]  cfg_div_b,
  input  logic              cfg_fixed,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              start,
  input  logic              stop,
  input  logic              done_clr,
  output logic              sh_clk,
  output logic              sh_dout,
  output logic              done,
  output logic              busy,
  output logic [1:0]        buf_full
);
  logic              wrap, mid, take, launch, word_valid;
  logic [WORD_W-1:0] word;
  clk_mode_e         mode;

  assign mode = cfg_fixed ? CLK_FIXED : CLK_FREE;

  pp_period_gen #(.DIV_W(DIV_W)) u_period (
    .clk    (clk),
    .rst    (rst),
    .launch (launch),
    .run    (busy),
    .div_a  (cfg_div_a),
    .div_b  (cfg_div_b),
    .wrap   (wrap),
    .mid    (mid)
  );

  pp_shadow_pair #(.WORD_W(WORD_W)) u_shadow (
    .clk       (clk),
    .rst       (rst),
    .ld_data   (ld_data),
    .ld        ({ld_buf1, ld_buf0}),
    .take      (take),
    .cur_word  (word),
    .cur_valid (word_valid),
    .full      (buf_full)
  );

  pp_serializer #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_ser (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .stop       (stop),
    .done_clr   (done_clr),
    .mode       (mode),
    .count      (cfg_count),
    .wrap       (wrap),
    .mid        (mid),
    .word       (word),
    .word_valid (word_valid),
    .take       (take),
    .launch     (launch),
    .active     (busy),
    .sh_clk     (sh_clk),
    .sh_dout    (sh_dout),
    .done       (done)
  );
endmodule

// File: rtl/pp_shift_tx_checker.sv
module pp_shift_tx_checker #(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] ld_data,
  input logic              ld_buf0,
  input logic              ld_buf1,
  input logic [DIV_W-1:0]  cfg_div_a,
  input logic [DIV_W-1:0]  cfg_div_b,
  input logic              cfg_fixed,
  input logic [CNT_W-1:0]  cfg_count,
  input logic              start,
  input logic              stop,
  input logic              done_clr,
  input logic              sh_clk,
  input logic              sh_dout,
  input logic              done,
  input logic              busy,
  input logic [1:0]        buf_full
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!busy && !done && !sh_clk && !sh_dout && buf_full == 2'b00));

  a_r3_data_moves_on_rise: assert property (@(posedge clk) disable iff (rst)
    !$stable(sh_dout) |-> ($rose(sh_clk) || !busy));

  a_r6_load0_sets_full: assert property (@(posedge clk) disable iff (rst)
    ld_buf0 |=> buf_full[0]);

  a_r6_load1_sets_full: assert property (@(posedge clk) disable iff (rst)
    ld_buf1 |=> buf_full[1]);

  a_r7_zero_count: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && cfg_fixed && cfg_count == '0) |=> (done && !busy));

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && !done_clr && !(start && !busy && cfg_fixed)) |=> done);

  a_r9_stop_ends: assert property (@(posedge clk) disable iff (rst)
    (busy && stop) |=> (!busy && !sh_clk && !sh_dout));

  a_r10_idle_clock_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sh_clk);
endmodule

bind pingpong_shift_tx pp_shift_tx_checker #(
  .WORD_W(WORD_W), .DIV_W(DIV_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/pingpong_shift_tx_test.sv
`timescale 1ns/1ps
module pingpong_shift_tx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ld_data = '0;
  logic        ld_buf0 = 1'b0, ld_buf1 = 1'b0;
  logic [7:0]  cfg_div_a = 8'd1, cfg_div_b = 8'd1;
  logic        cfg_fixed = 1'b0;
  logic [7:0]  cfg_count = '0;
  logic        start = 1'b0, stop = 1'b0, done_clr = 1'b0;
  logic        sh_clk, sh_dout, done, busy;
  logic [1:0]  buf_full;

  pingpong_shift_tx uut (.*);

  always #5 clk = ~clk;

  int n_checks = 0, n_err = 0, cyc = 0;
  bit finished = 0;
  int cap_n = 0, hi_bad = 0, exp_hi = 1, last_rise = 0, done_t = -1;
  bit cap_bits [128];
  int cap_t [128];
  logic prev_clk = 1'b0, prev_done = 1'b0;

  // {div_a, div_b, count, word0, word1}
  localparam logic [55:0] VEC [6] = '{
    {8'd1, 8'd1, 8'd32, 16'h8000, 16'h0012},
    {8'd2, 8'd1, 8'd20, 16'h0034, 16'h0056},
    {8'd3, 8'd2, 8'd16, 16'hA5C3, 16'h0000},
    {8'd0, 8'd5, 8'd24, 16'hFFFF, 16'h1234},
    {8'd2, 8'd2, 8'd40, 16'h8001, 16'h7FFE},
    {8'd4, 8'd1, 8'd1,  16'h8000, 16'hFFFF}
  };

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (sh_clk && !prev_clk) begin
      if (cap_n < 128) begin
        cap_bits[cap_n] = sh_dout;
        cap_t[cap_n]    = cyc;
      end
      last_rise = cyc;
      cap_n++;
    end
    if (!sh_clk && prev_clk && (cyc - last_rise) != exp_hi) hi_bad++;
    if (done && !prev_done) done_t = cyc;
    prev_clk  = sh_clk;
    prev_done = done;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int per_of(input int a, input int b);
    int ea = (a < 2) ? 1 : a;
    int eb = (b < 2) ? 1 : b;
    return (ea * eb < 2) ? 2 : ea * eb;
  endfunction

  function automatic bit exp_bit(input logic [15:0] w0, input logic [15:0] w1, input int k);
    if (k < 16) return w0[15-k];
    if (k < 32) return w1[31-k];
    return 1'b0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; start = 0; stop = 0; done_clr = 0; ld_buf0 = 0; ld_buf1 = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic load(input bit which, input logic [15:0] w);
    ld_data = w;
    if (which) ld_buf1 = 1'b1; else ld_buf0 = 1'b1;
    @(negedge clk);
    ld_buf0 = 1'b0; ld_buf1 = 1'b0;
  endtask

  task automatic pulse_start(output int t0);
    cap_n = 0; hi_bad = 0; done_t = -1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t0 = cyc;
  endtask

  task automatic wait_done(input int limit);
    for (int k = 0; k < limit && !done; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int t0;
    // R1: reset state, during and just after reset
    repeat (2) @(negedge clk);
    check(!sh_clk && !sh_dout && !busy && !done, "R1", "outputs in reset", {sh_clk, sh_dout, busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(buf_full == 2'b00 && !busy && !done && !sh_clk, "R1", "state after reset", {buf_full, busy, done, sh_clk}, 0);

    // Table walk: fixed-count transfers (R2, R3, R4, R5, R7)
    for (int i = 0; i < 6; i++) begin
      logic [55:0] v = VEC[i];
      int p = per_of(int'(v[55:48]), int'(v[47:40]));
      int cnt = int'(v[39:32]);
      int badk = -1, gapbad = -1;
      do_reset();
      load(1'b0, v[31:16]);
      load(1'b1, v[15:0]);
      exp_hi = p / 2;
      cfg_div_a = v[55:48]; cfg_div_b = v[47:40];
      cfg_fixed = 1'b1; cfg_count = v[39:32];
      pulse_start(t0);
      wait_done(cnt * p + 20);
      for (int k = 0; k < cnt && k < 128; k++)
        if (badk < 0 && cap_bits[k] != exp_bit(v[31:16], v[15:0], k)) badk = k;
      check(badk < 0, "R4", $sformatf("vec%0d first wrong bit index", i), badk, -1);
      check(cap_n == cnt, "R7", $sformatf("vec%0d clock rises", i), cap_n, cnt);
      for (int k = 1; k < cap_n && k < 128; k++)
        if (gapbad < 0 && cap_t[k] - cap_t[k-1] != p) gapbad = cap_t[k] - cap_t[k-1];
      check(gapbad < 0, "R2", $sformatf("vec%0d rise spacing", i), gapbad, p);
      check(hi_bad == 0, "R2", $sformatf("vec%0d high-time faults", i), hi_bad, 0);
      check(cap_t[0] == t0, "R3", $sformatf("vec%0d first rise cycle", i), cap_t[0] - t0, 0);
      check(done_t == t0 + cnt * p, "R7", $sformatf("vec%0d done cycle", i), done_t - t0, cnt * p);
      check(!busy && !sh_clk && done, "R7", $sformatf("vec%0d end state", i), {busy, sh_clk, done}, 1);
      if (cnt > 32) begin
        int zb = 0;
        for (int k = 32; k < cnt; k++) zb += cap_bits[k];
        check(zb == 0, "R5", $sformatf("vec%0d zero fill ones", i), zb, 0);
      end
    end

    // Free-running with refills and one empty boundary (R4, R5, R6, R9)
    begin
      logic [15:0] wseq [5] = '{16'h8000, 16'h0012, 16'h0034, 16'h0000, 16'h0056};
      int badk = -1, held;
      do_reset();
      load(1'b0, 16'h8000);
      load(1'b1, 16'h0012);
      check(buf_full == 2'b11, "R6", "both buffers full", buf_full, 3);
      exp_hi = 1;
      cfg_div_a = 8'd1; cfg_div_b = 8'd1; cfg_fixed = 1'b0;
      pulse_start(t0);
      check(buf_full == 2'b10, "R6", "buffer0 taken at start", buf_full, 2);
      load(1'b0, 16'h0034);
      wait (cap_n >= 20);
      @(negedge clk);
      start = 1'b1;             // R9: ignored while busy
      @(negedge clk);
      start = 1'b0;
      wait (cap_n >= 50);
      @(negedge clk);
      load(1'b1, 16'h0056);
      wait (cap_n >= 80);
      @(negedge clk);
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      check(!busy && !sh_clk && !sh_dout, "R9", "after stop", {busy, sh_clk, sh_dout}, 0);
      for (int k = 0; k < 80; k++)
        if (badk < 0 && cap_bits[k] != wseq[k/16][15 - (k % 16)]) badk = k;
      check(badk < 0, "R5", "free stream first wrong bit index", badk, -1);
      check(!done, "R8", "free run leaves done clear", done, 0);
      held = cap_n;
      repeat (6) @(negedge clk);
      check(cap_n == held && !sh_clk, "R10", "no clock after stop", cap_n - held, 0);
    end

    // Sticky done (R8) and zero-length request (R7)
    do_reset();
    cfg_div_a = 8'd1; cfg_div_b = 8'd1; cfg_fixed = 1'b1; cfg_count = 8'd4;
    pulse_start(t0);
    wait_done(40);
    repeat (10) @(negedge clk);
    check(done, "R8", "done holds", done, 1);
    cfg_fixed = 1'b0;
    pulse_start(t0);
    repeat (4) @(negedge clk);
    check(done && busy, "R8", "free start keeps done", {done, busy}, 3);
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    check(!done, "R8", "done_clr clears", done, 0);
    cfg_fixed = 1'b1; cfg_count = 8'd3;
    pulse_start(t0);
    wait_done(40);
    check(done, "R7", "short fixed run done", done, 1);
    cfg_count = 8'd8;
    pulse_start(t0);
    check(!done && busy, "R8", "fixed start clears done", {done, busy}, 1);
    wait_done(60);
    cfg_count = 8'd0;
    pulse_start(t0);
    check(done && !busy, "R7", "zero count done at once", {done, busy}, 2);
    repeat (4) @(negedge clk);
    check(cap_n == 0 && !sh_clk, "R10", "zero count gives no clock", cap_n, 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule